// File: doc/BRIEF.md
# Fan Lock Detect and Auto-Restart Timer

This block guards a single-phase fan motor against a stalled rotor. It receives a one-cycle strobe for every crossing of the two hall sensor signals and a slow timebase strobe. While crossings keep arriving, the motor counts as rotating. The lock indicator is pulled low and the high-side drivers are free. If a whole detection window of timebase ticks passes with no crossing, the block declares a lock. It then disables the high-side drivers and releases the lock indicator, so the open-drain line floats high.

A lock starts a protection period that is about ten times longer than the detection window. At the end of that period the block gives a one-cycle request to restart the motor in start-up mode. It frees the high side again and opens a new detection window, the retry window. The indicator stays released until a crossing arrives in the retry window. Then the block goes back to normal running. With no crossing in the retry window, another protection period follows, and the cycle repeats for as long as the rotor stays stalled. Both durations are parameters counted in ticks. With a 1 ms tick, the defaults give 0.75 s of drive attempt and 7 s off.

Top module: `fan_lock_guard`

## Requirements
- R1: After synchronous reset, the block is in normal running: `hs_off` = 0, `rd_pull_en` = 1, `restart_req` = 0, and a full detection window of `DET_TICKS` ticks is loaded.
- R2: In normal running, each `hall_xing` strobe reloads the window. The `DET_TICKS`-th tick with no crossing since the last reload declares a lock, and the outputs show it from the next clock cycle.
- R3: A crossing in the same cycle as the tick that would close the window takes priority: no lock is declared and the window is reloaded.
- R4: While locked, `hs_off` = 1 and `rd_pull_en` = 0 (indicator released).
- R5: The protection period lasts exactly `OFF_TICKS` ticks. `hall_xing` strobes during it are ignored and neither shorten nor extend it.
- R6: When the protection period ends, `restart_req` is high for exactly one clock cycle and `hs_off` returns to 0. `rd_pull_en` stays 0 during the retry window.
- R7: A crossing during the retry window returns the block to normal running, with `rd_pull_en` = 1 from the next cycle.
- R8: If the retry window of `DET_TICKS` ticks passes with no crossing, the block enters a new protection period (`hs_off` = 1).
- R9: Cycles without `tick` do not advance any timer, however many there are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase strobe; one pulse advances the active timer by one count |
| hall_xing | input | 1 | One-cycle strobe per hall signal crossing |
| hs_off | output | 1 | High-side driver disable (1 = high side off) |
| rd_pull_en | output | 1 | Lock indicator pull-down enable (1 = rotating, 0 = released) |
| restart_req | output | 1 | One-cycle request to restart the motor in start-up mode |

## Verification
The bench aims at the tick where the window closes. It places a crossing exactly on that tick, which a design that let expiry win would turn into a false lock, and it also lets the window run out by a single tick, which an off-by-one counter would miss or report late. It sends crossings during the protection period, which a design that listened to them would use to shorten the off time or drop back into normal running early. Random phases mix dense, sparse and absent crossings with gapped ticks, so that repeated retries happen and long tickless stretches occur. A design that counted clock cycles instead of ticks, or that held the restart request high for more than one cycle, would fail there.

// File: rtl/fan_lock_pkg.sv
package fan_lock_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_LOCKOFF = 2'd1,
        ST_RETRY   = 2'd2
    } lock_state_e;

    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/fan_lock_tick_counter.sv
module fan_lock_tick_counter #(
    parameter int CW      = 8,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expire = tick && (cnt == CW'(1));

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);                                                  // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));                          // R9

endmodule

// File: rtl/fan_lock_fsm.sv
module fan_lock_fsm
    import fan_lock_pkg::*;
#(
    parameter int CW        = 8,
    parameter int DET_TICKS = 5,
    parameter int OFF_TICKS = 48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hall_xing,
    input  logic          expire,
    output logic          load,
    output logic [CW-1:0] load_val,
    output lock_state_e   state,
    output logic          restart_req
);
    localparam logic [CW-1:0] DET_V = CW'(DET_TICKS);
    localparam logic [CW-1:0] OFF_V = CW'(OFF_TICKS);

    lock_state_e nxt;
    logic        rr_nxt;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = DET_V;
        rr_nxt   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (hall_xing) begin
                    load = 1'b1;
                end else if (expire) begin
                    nxt      = ST_LOCKOFF;
                    load     = 1'b1;
                    load_val = OFF_V;
                end
            end
            ST_LOCKOFF: begin
                if (expire) begin
                    nxt    = ST_RETRY;
                    load   = 1'b1;
                    rr_nxt = 1'b1;
                end
            end
            ST_RETRY: begin
                if (hall_xing) begin
                    nxt  = ST_RUN;
                    load = 1'b1;
                end else if (expire) begin
                    nxt      = ST_LOCKOFF;
                    load     = 1'b1;
                    load_val = OFF_V;
                end
            end
            default: begin
                nxt  = ST_RUN;
                load = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RUN;
            restart_req <= 1'b0;
        end else begin
            state       <= nxt;
            restart_req <= rr_nxt;
        end
    end

    AST_RESTART_AFTER_OFF: assert property (@(posedge clk) disable iff (rst)
        restart_req |-> ($past(state) == ST_LOCKOFF && state == ST_RETRY));  // R6
    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
        restart_req |=> !restart_req);                                       // R6
    AST_HALL_IGNORED_OFF: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKOFF && !expire) |=> state == ST_LOCKOFF);           // R5
    AST_RETRY_RESUME: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RETRY && hall_xing) |=> state == ST_RUN);               // R7
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && hall_xing) |=> state == ST_RUN);                 // R3

endmodule

// File: rtl/fan_lock_guard.sv
module fan_lock_guard
    import fan_lock_pkg::*;
#(
    parameter int DET_TICKS = 750,
    parameter int OFF_TICKS = 7000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hall_xing,
    output logic hs_off,
    output logic rd_pull_en,
    output logic restart_req
);
    localparam int CW = cnt_width(DET_TICKS, OFF_TICKS);

    logic          load;
    logic [CW-1:0] load_val;
    logic          expire;
    lock_state_e   state;

    fan_lock_tick_counter #(
        .CW      (CW),
        .RST_VAL (DET_TICKS)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .expire   (expire)
    );

    fan_lock_fsm #(
        .CW        (CW),
        .DET_TICKS (DET_TICKS),
        .OFF_TICKS (OFF_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .hall_xing   (hall_xing),
        .expire      (expire),
        .load        (load),
        .load_val    (load_val),
        .state       (state),
        .restart_req (restart_req)
    );

    always_comb begin
        hs_off     = (state == ST_LOCKOFF);
        rd_pull_en = (state == ST_RUN);
    end

    AST_LOCK_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        hs_off |-> (!rd_pull_en && !restart_req));                   // R4
    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_off) |-> $past(tick));                              // R9

endmodule

// File: tb/tb_fan_lock_guard.sv
module tb_fan_lock_guard;
    localparam int DET = 5;
    localparam int OFF = 48;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, tick, hall_xing;
    logic hs_off, rd_pull_en, restart_req;

    int checks = 0;
    int fails  = 0;
    int m_state;
    int m_cnt;
    bit m_rr;

    fan_lock_guard #(.DET_TICKS(DET), .OFF_TICKS(OFF)) dut (
        .clk(clk), .rst(rst), .tick(tick), .hall_xing(hall_xing),
        .hs_off(hs_off), .rd_pull_en(rd_pull_en), .restart_req(restart_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_step(input bit tk, input bit hl);
        bit ex;
        ex   = tk && (m_cnt == 1);
        m_rr = 1'b0;
        case (m_state)
            0: if (hl) m_cnt = DET;
               else if (ex) begin m_state = 1; m_cnt = OFF; end
               else if (tk) m_cnt--;
            1: if (ex) begin m_state = 2; m_cnt = DET; m_rr = 1'b1; end
               else if (tk) m_cnt--;
            default: if (hl) begin m_state = 0; m_cnt = DET; end
               else if (ex) begin m_state = 1; m_cnt = OFF; end
               else if (tk) m_cnt--;
        endcase
    endfunction

    task automatic step(input bit tk, input bit hl);
        tick      = tk;
        hall_xing = hl;
        model_step(tk, hl);
        @(posedge clk);
        @(negedge clk);
        chk("R4 hs_off model", hs_off, m_state == 1);
        chk("R7 rd_pull_en model", rd_pull_en, m_state == 0);
        chk("R6 restart_req model", restart_req, m_rr);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hp;
        void'($urandom(1234));
        rst = 1'b1; tick = 1'b0; hall_xing = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_state = 0; m_cnt = DET; m_rr = 1'b0;
        chk("R1 hs_off", hs_off, 1'b0);
        chk("R1 rd_pull_en", rd_pull_en, 1'b1);
        chk("R1 restart_req", restart_req, 1'b0);

        // R3: crossing on the closing tick wins
        for (int i = 0; i < DET - 1; i++) step(1, 0);
        step(1, 1);
        chk("R3 no lock on tied tick", hs_off, 1'b0);
        for (int i = 0; i < DET - 1; i++) step(1, 0);
        chk("R2 window still open", hs_off, 1'b0);
        step(1, 0);
        chk("R2 lock after full window", hs_off, 1'b1);
        chk("R4 indicator released", rd_pull_en, 1'b0);

        // R5: crossings ignored during the off period
        for (int i = 0; i < OFF - 1; i++) step(1, (i % 3) == 0);
        chk("R5 still off before last tick", hs_off, 1'b1);
        step(1, 1);
        chk("R6 restart pulse", restart_req, 1'b1);
        chk("R6 high side freed", hs_off, 1'b0);
        chk("R6 indicator still released", rd_pull_en, 1'b0);
        step(0, 0);
        chk("R6 pulse is one cycle", restart_req, 1'b0);

        // R8: retry window lapses
        for (int i = 0; i < DET; i++) step(1, 0);
        chk("R8 relock after retry", hs_off, 1'b1);
        for (int i = 0; i < OFF; i++) step(1, 0);
        step(0, 1);
        chk("R7 resume on retry crossing", rd_pull_en, 1'b1);

        // R9: no ticks, no progress
        for (int i = 0; i < 100; i++) step(0, 0);
        chk("R9 no lock without ticks", hs_off, 1'b0);

        // random phases
        for (int ph = 0; ph < 20; ph++) begin
            case ($urandom % 3)
                0: hp = 0;
                1: hp = 20;
                default: hp = 4;
            endcase
            for (int i = 0; i < 200; i++)
                step(($urandom % 2) == 0, (hp != 0) && (($urandom % hp) == 0));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule